// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block decides which oscillator clocks the system and keeps the PLL divider settings consistent with that choice. Software writes a small register space: a PLL input prescaler, a feedback divider, two output postscalers, and a switch command that carries a target source code and a start bit. The sequencer checks every command against the PLL rules and either refuses it or starts a handshake. The handshake waits for the target oscillator, and for the PLL lock where the target uses one, to stay ready for a fixed number of cycles. Only then does the active source change.

While a PLL source is active, the prescaler and feedback divider are frozen. A jump from one PLL source straight to another is refused. A PLL target is accepted only when the input, phase-detector and VCO frequencies derived from the current settings all fall in their legal windows; a rejected target raises a sticky error flag. The two oscillator frequencies are parameters. Two configuration inputs, sampled during reset, choose the boot source and enable a two-speed start-up. In that start-up the system first runs on the internal fast RC oscillator and then moves to the selected PLL source on its own once the PLL is ready.

Top module: `clksw_seq`

## Requirements
- R1: When reset ends with boot source 3'b000 and two-speed start-up off, the active source reads 3'b000, the start bit and the error flag read 0, and the dividers read prescaler 1, feedback 125, postscaler1 5 and postscaler2 1.
- R2: The write address selects the field. Address 0 holds the prescaler (data[3:0]) and address 1 the feedback divider (data[7:0]). Address 2 holds postscaler1 (data[2:0]) and postscaler2 (data[6:4]). A written value reads back on the next cycle when no lock applies.
- R3: Writes to the prescaler or feedback divider leave them unchanged while the active source is a PLL source (code bit 0 set) or while a switch to a PLL source is pending. Postscaler writes are always taken.
- R4: A write to address 3 with data[7]=1 requests a switch to the source code in data[2:0]. The codes are 3'b000 fast RC, 3'b001 fast RC with PLL, 3'b010 primary oscillator and 3'b011 primary oscillator with PLL. An accepted request makes the start bit read 1 from the next cycle until the switch completes.
- R5: A switch completes only on the cycle in which the target's ready signal has been high for RDY_CYCLES consecutive cycles. The ready signal is the oscillator ready, ANDed with the PLL lock for a PLL code. Any low cycle restarts the count. The active source takes the target code in the same cycle that the start bit clears.
- R6: A request for a PLL source while a PLL source is active is refused. The start bit stays 0, the active source is kept and the error flag is not set.
- R7: A request for a PLL source is refused, the error flag is set and the active source is kept if any rule fails. The rules are: PLL input frequency 8 to 64 MHz; phase-detector frequency (input / prescaler) at least 8 MHz and at most VCO / 16; VCO frequency (input × feedback / prescaler) 400 to 1600 MHz, bounds included; no divider is zero.
- R8: A request with code bit 2 set is refused without setting the error flag.
- R9: A request written while a switch is pending is ignored.
- R10: With two-speed start-up on and a PLL boot source, reset ends on source 3'b000 with the start bit at 1. The switch to the boot source then completes automatically under the rule of R5.
- R11: With two-speed start-up off, reset ends directly on the boot source if its bit 2 is 0, and on 3'b000 otherwise.
- R12: A write to address 3 with data[6]=1 clears the error flag; an error raised by the same write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the currently active source |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_src | input | 3 | Boot source code, sampled during reset |
| two_speed | input | 1 | Two-speed start-up enable, sampled during reset |
| frc_rdy | input | 1 | Fast RC oscillator ready |
| posc_rdy | input | 1 | Primary oscillator ready |
| pll_lock | input | 1 | PLL locked |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| cur_src | output | 3 | Active source code |
| swen | output | 1 | Switch start bit, 1 while a switch is pending |
| cfg_err | output | 1 | Sticky frequency-rule error |
| pre_val | output | 4 | Prescaler setting |
| fbd_val | output | 8 | Feedback divider setting |
| post1_val | output | 3 | Postscaler 1 setting |
| post2_val | output | 3 | Postscaler 2 setting |

## Verification
Every cycle, the assertions check four things. The active source changes only when the start bit falls, takes the pending target and follows a cycle of target readiness. It never moves from one PLL source to another. The locked divider fields hold still across writes while a PLL source is active. The frequency windows, including both VCO bounds and the phase-detector limit, can only be shown by the bench's vector table of divider settings. The same holds for the exact completion cycle after readiness drops and returns, the ignored mid-switch request, and the reset-time boot choices.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    localparam int PRE_W  = 4;
    localparam int FBD_W  = 8;
    localparam int POST_W = 3;
    localparam int SRC_W  = 3;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    // source codes: bit 0 marks a PLL source, bit 1 the primary oscillator
    localparam logic [SRC_W-1:0] SRC_FRC      = 3'b000;
    localparam logic [SRC_W-1:0] SRC_FRC_PLL  = 3'b001;
    localparam logic [SRC_W-1:0] SRC_POSC     = 3'b010;
    localparam logic [SRC_W-1:0] SRC_POSC_PLL = 3'b011;

    localparam logic [ADDR_W-1:0] A_PRE  = 2'd0;
    localparam logic [ADDR_W-1:0] A_FBD  = 2'd1;
    localparam logic [ADDR_W-1:0] A_POST = 2'd2;
    localparam logic [ADDR_W-1:0] A_SW   = 2'd3;

    localparam int BIT_GO  = 7;
    localparam int BIT_CLR = 6;
    localparam int POST2_LSB = 4;

    // legal windows in MHz
    localparam int PLLI_MIN = 8;
    localparam int PLLI_MAX = 64;
    localparam int PFD_MIN  = 8;
    localparam int PFD_RATIO = 16;
    localparam int VCO_MIN  = 400;
    localparam int VCO_MAX  = 1600;

    localparam logic [PRE_W-1:0]  PRE_RST   = 4'd1;
    localparam logic [FBD_W-1:0]  FBD_RST   = 8'd125;
    localparam logic [POST_W-1:0] POST1_RST = 3'd5;
    localparam logic [POST_W-1:0] POST2_RST = 3'd1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [FBD_W-1:0]  fbd;
        logic [POST_W-1:0] post1;
        logic [POST_W-1:0] post2;
        logic [SRC_W-1:0]  cur;
        logic [SRC_W-1:0]  tgt;
        logic              pend;
        logic              err;
    } seq_state_t;

endpackage

// File: rtl/clksw_freq_chk.sv
module clksw_freq_chk
    import clksw_pkg::*;
#(
    parameter int FRC_MHZ  = 8,
    parameter int POSC_MHZ = 16
) (
    input  logic              src_posc,
    input  logic [PRE_W-1:0]  pre,
    input  logic [FBD_W-1:0]  fbd,
    input  logic [POST_W-1:0] post1,
    input  logic [POST_W-1:0] post2,
    output logic              ok
);

    int fin;
    int pre_i;
    int fbd_i;
    int vco_x_pre;

    always_comb begin
        fin       = src_posc ? POSC_MHZ : FRC_MHZ;
        pre_i     = int'(pre);
        fbd_i     = int'(fbd);
        // VCO scaled by the prescaler keeps the check free of division
        vco_x_pre = fin * fbd_i;
        ok = (pre != '0) && (post1 != '0) && (post2 != '0)
          && (fin >= PLLI_MIN) && (fin <= PLLI_MAX)
          && (fin >= PFD_MIN * pre_i)
          && (fbd_i >= PFD_RATIO)
          && (vco_x_pre >= VCO_MIN * pre_i)
          && (vco_x_pre <= VCO_MAX * pre_i);
    end

endmodule

// File: rtl/clksw_rdy_cnt.sv
module clksw_rdy_cnt #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic rdy,
    output logic done
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = arm && rdy && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!arm || !rdy || done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
    import clksw_pkg::*;
#(
    parameter int FRC_MHZ    = 8,
    parameter int POSC_MHZ   = 16,
    parameter int RDY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        boot_src,
    input  logic              two_speed,
    input  logic              frc_rdy,
    input  logic              posc_rdy,
    input  logic              pll_lock,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [2:0]        cur_src,
    output logic              swen,
    output logic              cfg_err,
    output logic [3:0]        pre_val,
    output logic [7:0]        fbd_val,
    output logic [2:0]        post1_val,
    output logic [2:0]        post2_val
);

    seq_state_t q, d, rst_val;

    logic [SRC_W-1:0] req_tgt;
    logic [SRC_W-1:0] tgt_q;
    logic             req;
    logic             freq_ok;
    logic             tgt_rdy;
    logic             cnt_done;
    logic             div_lock;

    assign req_tgt = wr_data[SRC_W-1:0];
    assign tgt_q   = q.tgt;

    clksw_freq_chk #(
        .FRC_MHZ (FRC_MHZ),
        .POSC_MHZ(POSC_MHZ)
    ) i_freq (
        .src_posc(req_tgt[1]),
        .pre     (q.pre),
        .fbd     (q.fbd),
        .post1   (q.post1),
        .post2   (q.post2),
        .ok      (freq_ok)
    );

    clksw_rdy_cnt #(
        .CYCLES(RDY_CYCLES)
    ) i_rdy (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (q.pend),
        .rdy  (tgt_rdy),
        .done (cnt_done)
    );

    // readiness of the pending target
    always_comb begin
        unique case (q.tgt[1:0])
            2'b00:   tgt_rdy = frc_rdy;
            2'b01:   tgt_rdy = frc_rdy & pll_lock;
            2'b10:   tgt_rdy = posc_rdy;
            default: tgt_rdy = posc_rdy & pll_lock;
        endcase
    end

    // state taken while reset is held
    always_comb begin
        rst_val       = '0;
        rst_val.pre   = PRE_RST;
        rst_val.fbd   = FBD_RST;
        rst_val.post1 = POST1_RST;
        rst_val.post2 = POST2_RST;
        rst_val.cur   = SRC_FRC;
        rst_val.tgt   = SRC_FRC;
        if (!boot_src[2]) begin
            if (two_speed && boot_src[0]) begin
                rst_val.tgt  = boot_src;
                rst_val.pend = 1'b1;
            end else begin
                rst_val.cur = boot_src;
                rst_val.tgt = boot_src;
            end
        end
    end

    always_comb begin
        d        = q;
        div_lock = q.cur[0] | (q.pend & q.tgt[0]);
        req      = wr_en && (wr_addr == A_SW) && wr_data[BIT_GO] && !q.pend;

        if (wr_en) begin
            unique case (wr_addr)
                A_PRE: begin
                    if (!div_lock) d.pre = wr_data[PRE_W-1:0];
                end
                A_FBD: begin
                    if (!div_lock) d.fbd = wr_data[FBD_W-1:0];
                end
                A_POST: begin
                    d.post1 = wr_data[POST_W-1:0];
                    d.post2 = wr_data[POST2_LSB +: POST_W];
                end
                default: begin
                    if (wr_data[BIT_CLR]) d.err = 1'b0;
                end
            endcase
        end

        if (q.pend && cnt_done) begin
            d.cur  = q.tgt;
            d.pend = 1'b0;
        end

        if (req) begin
            if (req_tgt[2]) begin
                d.pend = 1'b0;
            end else if (req_tgt[0] && q.cur[0]) begin
                d.pend = 1'b0;
            end else if (req_tgt[0] && !freq_ok) begin
                d.err = 1'b1;
            end else begin
                d.tgt  = req_tgt;
                d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= rst_val;
        end else begin
            q <= d;
        end
    end

    assign cur_src   = q.cur;
    assign swen      = q.pend;
    assign cfg_err   = q.err;
    assign pre_val   = q.pre;
    assign fbd_val   = q.fbd;
    assign post1_val = q.post1;
    assign post2_val = q.post2;

endmodule

// File: rtl/clksw_seq_chk.sv
module clksw_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [2:0] cur_src,
    input logic       swen,
    input logic [3:0] pre_val,
    input logic [7:0] fbd_val,
    input logic [2:0] tgt_q,
    input logic       tgt_rdy
);

    assert_src_moves_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> ($fell(swen) && (cur_src == $past(tgt_q))));

    assert_done_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swen) |-> $past(tgt_rdy));

    assert_no_pll_hop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> !($past(cur_src[0]) && cur_src[0]));

    assert_pre_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd0) && cur_src[0]) |=> $stable(pre_val));

    assert_fbd_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 2'd1) && cur_src[0]) |=> $stable(fbd_val));

    assert_src_code_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_src[2]);

endmodule

bind clksw_seq clksw_seq_chk i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .cur_src(cur_src),
    .swen   (swen),
    .pre_val(pre_val),
    .fbd_val(fbd_val),
    .tgt_q  (tgt_q),
    .tgt_rdy(tgt_rdy)
);

// File: tb/test_clksw_seq.sv
`timescale 1ns/1ps
module test_clksw_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] boot_src = 3'b000;
    logic       two_speed = 1'b0;
    logic       frc_rdy = 1'b1;
    logic       posc_rdy = 1'b1;
    logic       pll_lock = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] cur_src;
    logic       swen;
    logic       cfg_err;
    logic [3:0] pre_val;
    logic [7:0] fbd_val;
    logic [2:0] post1_val;
    logic [2:0] post2_val;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    clksw_seq i_clksw_seq (
        .clk(clk), .rst_n(rst_n), .boot_src(boot_src), .two_speed(two_speed),
        .frc_rdy(frc_rdy), .posc_rdy(posc_rdy), .pll_lock(pll_lock),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cur_src(cur_src), .swen(swen), .cfg_err(cfg_err),
        .pre_val(pre_val), .fbd_val(fbd_val),
        .post1_val(post1_val), .post2_val(post2_val)
    );

    typedef struct packed {
        logic       posc;
        logic [3:0] pre;
        logic [7:0] fbd;
        logic [2:0] p1;
        logic [2:0] p2;
        logic       ok;
    } vec_t;

    // FRC = 8 MHz, primary = 16 MHz
    localparam vec_t VECS [10] = '{
        '{1'b0, 4'd1, 8'd125, 3'd5, 3'd1, 1'b1},  // VCO 1000
        '{1'b0, 4'd1, 8'd50,  3'd2, 3'd1, 1'b1},  // VCO 400, lower bound
        '{1'b0, 4'd1, 8'd49,  3'd2, 3'd1, 1'b0},  // VCO 392
        '{1'b0, 4'd1, 8'd200, 3'd4, 3'd2, 1'b1},  // VCO 1600, upper bound
        '{1'b0, 4'd1, 8'd201, 3'd4, 3'd2, 1'b0},  // VCO 1608
        '{1'b0, 4'd2, 8'd125, 3'd5, 3'd1, 1'b0},  // PFD 4 MHz
        '{1'b1, 4'd2, 8'd100, 3'd4, 3'd1, 1'b1},  // PFD 8, VCO 800
        '{1'b1, 4'd3, 8'd150, 3'd4, 3'd1, 1'b0},  // PFD below 8
        '{1'b1, 4'd1, 8'd100, 3'd7, 3'd7, 1'b1},  // VCO 1600
        '{1'b0, 4'd1, 8'd125, 3'd0, 3'd1, 1'b0}   // zero postscaler
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (swen && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " switch completes"}, int'(swen), 0);
    endtask

    task automatic do_reset(input logic [2:0] b, input logic ts);
        @(negedge clk);
        rst_n = 1'b0; boot_src = b; two_speed = ts;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(3'b000, 1'b0);
        chk("R1 cur_src", int'(cur_src), 0);
        chk("R1 swen", int'(swen), 0);
        chk("R1 err", int'(cfg_err), 0);
        chk("R1 pre", int'(pre_val), 1);
        chk("R1 fbd", int'(fbd_val), 125);
        chk("R1 post1", int'(post1_val), 5);
        chk("R1 post2", int'(post2_val), 1);

        // R2: field writes from a non-PLL source
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd100);
        wr(2'd2, {1'b0, 3'd2, 1'b0, 3'd4});
        chk("R2 pre", int'(pre_val), 1);
        chk("R2 fbd", int'(fbd_val), 100);
        chk("R2 post1", int'(post1_val), 4);
        chk("R2 post2", int'(post2_val), 2);

        // R4/R5/R9: switch to FRC+PLL with readiness held off
        pll_lock = 1'b0;
        wr(2'd3, 8'h81);
        chk("R4 swen set", int'(swen), 1);
        wr(2'd3, 8'h82);                       // R9: ignored while pending
        repeat (4) @(negedge clk);
        chk("R5 waits for ready", int'(cur_src), 0);
        chk("R5 swen held", int'(swen), 1);
        pll_lock = 1'b1;
        repeat (2) @(negedge clk);
        pll_lock = 1'b0;                       // count restarts
        @(negedge clk);
        pll_lock = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 not yet done", int'(swen), 1);
        chk("R5 source not yet moved", int'(cur_src), 0);
        @(negedge clk);
        chk("R5 swen clears", int'(swen), 0);
        chk("R9 target kept", int'(cur_src), 1);

        // R3: divider lock on a PLL source
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd60);
        wr(2'd2, {1'b0, 3'd1, 1'b0, 3'd3});
        chk("R3 pre frozen", int'(pre_val), 1);
        chk("R3 fbd frozen", int'(fbd_val), 100);
        chk("R3 post1 taken", int'(post1_val), 3);
        chk("R3 post2 taken", int'(post2_val), 1);

        // R6: PLL to PLL refused
        wr(2'd3, 8'h83);
        chk("R6 swen", int'(swen), 0);
        chk("R6 err", int'(cfg_err), 0);
        repeat (6) @(negedge clk);
        chk("R6 source kept", int'(cur_src), 1);

        // R8: reserved code refused
        wr(2'd3, 8'h85);
        chk("R8 swen", int'(swen), 0);
        chk("R8 err", int'(cfg_err), 0);
        chk("R8 source kept", int'(cur_src), 1);

        // back to FRC; dividers unlock
        wr(2'd3, 8'h80);
        wait_done("R4");
        chk("R4 back on FRC", int'(cur_src), 0);
        wr(2'd1, 8'd125);
        chk("R3 fbd unlocked", int'(fbd_val), 125);

        // R7: frequency table
        foreach (VECS[i]) begin
            logic [2:0] tgt;
            tgt = VECS[i].posc ? 3'b011 : 3'b001;
            wr(2'd0, {4'd0, VECS[i].pre});
            wr(2'd1, VECS[i].fbd);
            wr(2'd2, {1'b0, VECS[i].p2, 1'b0, VECS[i].p1});
            wr(2'd3, {2'b11, 3'b000, tgt});
            if (VECS[i].ok) begin
                chk($sformatf("R7 vec%0d accepted", i), int'(swen), 1);
                wait_done("R7");
                chk($sformatf("R7 vec%0d source", i), int'(cur_src), int'(tgt));
                chk($sformatf("R7 vec%0d no err", i), int'(cfg_err), 0);
                wr(2'd3, 8'h80);
                wait_done("R7");
                chk($sformatf("R7 vec%0d return", i), int'(cur_src), 0);
            end else begin
                chk($sformatf("R7 vec%0d refused", i), int'(swen), 0);
                chk($sformatf("R7 vec%0d err", i), int'(cfg_err), 1);
                repeat (6) @(negedge clk);
                chk($sformatf("R7 vec%0d source kept", i), int'(cur_src), 0);
            end
        end

        // R12: error clear (last vector left the flag set)
        chk("R12 err before clear", int'(cfg_err), 1);
        wr(2'd3, 8'h40);
        chk("R12 err cleared", int'(cfg_err), 0);

        // R10: two-speed start-up
        pll_lock = 1'b0;
        do_reset(3'b001, 1'b1);
        chk("R10 starts on FRC", int'(cur_src), 0);
        chk("R10 swen pending", int'(swen), 1);
        repeat (3) @(negedge clk);
        chk("R10 waits for lock", int'(cur_src), 0);
        pll_lock = 1'b1;
        wait_done("R10");
        chk("R10 handover", int'(cur_src), 1);

        // R11: direct boot
        do_reset(3'b011, 1'b0);
        chk("R11 boot PLL direct", int'(cur_src), 3);
        chk("R11 no pending", int'(swen), 0);
        do_reset(3'b110, 1'b0);
        chk("R11 reserved boot", int'(cur_src), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule